// File: doc/BRIEF.md
# Cascadable Dual 8-bit Reload Timer

The block holds two 8-bit down counters, a low one and a high one, that either run independently or join into one 16-bit timer. Each counter reloads from its own reload value when it passes zero and when its load strobe is pulsed. While the cascade bit is clear, each counter has its own run bit, load strobe and step input. The low counter steps either on an internal prescaled tick or, in event mode, on edges of an external strobe. The polarity bit selects rising or falling edges.

While the cascade bit is set, the low counter's wrap is the only step source for the high counter. The low counter's run bit and load strobe then govern both bytes, and the high counter's own controls have no effect. The timer has two interrupt pulses, one for each counter, and a square-wave output. The square wave follows the underflow of the active timer: the low counter alone, or the combined 16-bit timer.

Software reads the two counters through a 4-bit port, one nibble per read strobe, in a fixed order from low to high. A small read sequencer has four states: RD_NIB0, RD_NIB1, RD_NIB2 and RD_NIB3. Every read strobe moves it one state forward: RD_NIB0 to RD_NIB1, RD_NIB1 to RD_NIB2, RD_NIB2 to RD_NIB3, and RD_NIB3 back to RD_NIB0. Without a strobe it holds its state. The read taken in RD_NIB0 also captures all 16 bits, so the next three reads return parts of one consistent value.

Top module: `casc_reload_timer`

## Requirements
- R1: A load strobe (`lo_load`, or `hi_load` when not cascaded) sets its counter to its reload value at the next clock edge. This happens whether the counter is running or stopped.
- R2: On each clock edge where its run bit and step input are both high, a counter holding a nonzero value decrements by one. With the run bit low, the counter holds its value.
- R3: A running counter at zero that gets a step reloads from its reload value. The matching interrupt output (`lo_irq`, or `hi_irq` when not cascaded) is then high for exactly the one cycle after that edge.
- R4: With `evt_mode`=1, the low counter steps on edges of `evt_in` and ignores `tick`. `evt_rise`=1 selects 0-to-1 edges and `evt_rise`=0 selects 1-to-0 edges. The edge is taken against the `evt_in` value sampled at the previous clock edge.
- R5: With `cascade`=1, the high counter steps only on a low-counter wrap. It runs and loads under `lo_run` and `lo_load`. The inputs `hi_run`, `hi_load` and `hi_tick` have no effect.
- R6: With `cascade`=1, an underflow occurs only when a step arrives while both bytes are zero. Both bytes then reload, `lo_irq` pulses once, and `hi_irq` stays low.
- R7: `tout` toggles in the same cycle that `lo_irq` rises for an active-timer underflow, and it changes at no other time.
- R8: `rd_data` is registered and updates on the edge that samples `rd_en`. The first read returns the low count bits 3..0 and captures both counts. The next three reads return the captured low bits 7..4, high bits 3..0 and high bits 7..4, and then the order starts again. Without `rd_en`, `rd_data` holds.
- R9: While `rst_n` is low, both counts, `rd_data`, `lo_irq`, `hi_irq` and `tout` go to zero, and the sequencer returns to the first nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cascade | input | 1 | 1 joins the counters into one 16-bit timer |
| tick | input | 1 | Prescaled internal step for the low counter |
| evt_in | input | 1 | External event level |
| evt_mode | input | 1 | 1 steps the low counter on event edges |
| evt_rise | input | 1 | Event edge select: 1 rising, 0 falling |
| lo_run | input | 1 | Low counter run bit (both counters when cascaded) |
| lo_load | input | 1 | Low counter load strobe (both counters when cascaded) |
| lo_reload | input | 8 | Low counter reload value |
| hi_tick | input | 1 | High counter step when not cascaded |
| hi_run | input | 1 | High counter run bit when not cascaded |
| hi_load | input | 1 | High counter load strobe when not cascaded |
| hi_reload | input | 8 | High counter reload value |
| rd_en | input | 1 | Nibble read strobe |
| rd_data | output | 4 | Nibble read result |
| lo_irq | output | 1 | Low or combined underflow pulse |
| hi_irq | output | 1 | High counter underflow pulse (separate mode only) |
| tout | output | 1 | Square wave toggled on active underflow |

## Verification
The bench drives separate mode with a steady tick, a sparse high-counter tick and stop periods. These patterns tell apart the decrement, the hold and the reload at zero. In event mode it toggles the event level while the tick stays high and tries both polarities. This shows whether the counter follows the correct edge and ignores the tick. In cascade mode the high controls are exercised on purpose, which exposes any leak of `hi_run`, `hi_load` or `hi_tick`. A long random phase then mixes load strobes, mode changes and read strobes in the middle of a read order. This checks that captured reads stay consistent while the counters move.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int CNT_W = 8;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        RD_NIB0 = 2'd0,
        RD_NIB1 = 2'd1,
        RD_NIB2 = 2'd2,
        RD_NIB3 = 2'd3
    } rd_state_t;
endpackage

// File: rtl/crt_down_ctr.sv
module crt_down_ctr #(
    parameter int W = crt_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         run_i,
    input  logic         step_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);
    assign wrap_o  = !load_i && run_i && step_i && at_zero;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload_i;
        end else if (run_i && step_i) begin
            if (at_zero) cnt_q <= reload_i;
            else         cnt_q <= cnt_q - 1'b1;
        end
    end

    // R1: a load strobe forces the reload value
    a_r1_load_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_o == $past(reload_i));
    // R2: a running step decrements a nonzero count
    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && run_i && step_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);
    // R2: a stopped counter holds
    a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> $stable(cnt_o));
    // R3: a step at zero reloads
    a_r3_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> cnt_o == $past(reload_i));
endmodule

// File: rtl/crt_evt_edge.sv
module crt_evt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= evt_i;
    end

    always_comb begin
        if (rise_sel_i) edge_o = evt_i && !prev_q;
        else            edge_o = !evt_i && prev_q;
    end
endmodule

// File: rtl/crt_nib_reader.sv
module crt_nib_reader
    import crt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NW = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_i,
    input  logic [W-1:0]  lo_cnt_i,
    input  logic [W-1:0]  hi_cnt_i,
    output logic [NW-1:0] rd_data_o
);
    localparam int SNAP_W = 2 * W;

    rd_state_t        state_q, state_d;
    logic [SNAP_W-1:0] snap_q;
    logic [NW-1:0]     data_q;

    always_comb begin
        state_d = state_q;
        if (rd_en_i) begin
            unique case (state_q)
                RD_NIB0: state_d = RD_NIB1;
                RD_NIB1: state_d = RD_NIB2;
                RD_NIB2: state_d = RD_NIB3;
                RD_NIB3: state_d = RD_NIB0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_NIB0;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            data_q <= '0;
        end else if (rd_en_i) begin
            unique case (state_q)
                RD_NIB0: begin
                    snap_q <= {hi_cnt_i, lo_cnt_i};
                    data_q <= lo_cnt_i[NW-1:0];
                end
                RD_NIB1: data_q <= snap_q[1*NW +: NW];
                RD_NIB2: data_q <= snap_q[2*NW +: NW];
                RD_NIB3: data_q <= snap_q[3*NW +: NW];
            endcase
        end
    end

    assign rd_data_o = data_q;

    // R8: the first read returns the live low nibble
    a_r8_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && state_q == RD_NIB0) |=> rd_data_o == $past(lo_cnt_i[NW-1:0]));
    // R8: no strobe, no change
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o) && $stable(state_q));
    // R8: the order starts again after the last nibble
    a_r8_order_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && state_q == RD_NIB3) |=> state_q == RD_NIB0);
endmodule

// File: rtl/casc_reload_timer.sv
module casc_reload_timer
    import crt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NW = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cascade,
    input  logic          tick,
    input  logic          evt_in,
    input  logic          evt_mode,
    input  logic          evt_rise,
    input  logic          lo_run,
    input  logic          lo_load,
    input  logic [W-1:0]  lo_reload,
    input  logic          hi_tick,
    input  logic          hi_run,
    input  logic          hi_load,
    input  logic [W-1:0]  hi_reload,
    input  logic          rd_en,
    output logic [NW-1:0] rd_data,
    output logic          lo_irq,
    output logic          hi_irq,
    output logic          tout
);
    logic         evt_edge, lo_step, lo_wrap;
    logic         hi_step, hi_run_eff, hi_load_eff, hi_wrap;
    logic         active_uf;
    logic [W-1:0] lo_cnt, hi_cnt;
    logic         lo_irq_q, hi_irq_q, tout_q;

    crt_evt_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_in),
        .rise_sel_i (evt_rise),
        .edge_o     (evt_edge)
    );

    assign lo_step = evt_mode ? evt_edge : tick;

    crt_down_ctr #(.W(W)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (lo_load),
        .run_i    (lo_run),
        .step_i   (lo_step),
        .reload_i (lo_reload),
        .cnt_o    (lo_cnt),
        .wrap_o   (lo_wrap)
    );

    always_comb begin
        if (cascade) begin
            hi_step     = lo_wrap;
            hi_run_eff  = lo_run;
            hi_load_eff = lo_load;
        end else begin
            hi_step     = hi_tick;
            hi_run_eff  = hi_run;
            hi_load_eff = hi_load;
        end
    end

    crt_down_ctr #(.W(W)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (hi_load_eff),
        .run_i    (hi_run_eff),
        .step_i   (hi_step),
        .reload_i (hi_reload),
        .cnt_o    (hi_cnt),
        .wrap_o   (hi_wrap)
    );

    assign active_uf = cascade ? hi_wrap : lo_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_irq_q <= 1'b0;
            hi_irq_q <= 1'b0;
            tout_q   <= 1'b0;
        end else begin
            lo_irq_q <= active_uf;
            hi_irq_q <= !cascade && hi_wrap;
            tout_q   <= tout_q ^ active_uf;
        end
    end

    assign lo_irq = lo_irq_q;
    assign hi_irq = hi_irq_q;
    assign tout   = tout_q;

    crt_nib_reader #(.W(W), .NW(NW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en),
        .lo_cnt_i  (lo_cnt),
        .hi_cnt_i  (hi_cnt),
        .rd_data_o (rd_data)
    );

    // R5: cascaded high byte moves only on a low wrap or a low load
    a_r5_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && !lo_wrap && !lo_load) |=> $stable(hi_cnt));
    // R6: no separate high interrupt while cascaded
    a_r6_no_hi_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cascade) |-> !hi_irq);
    // R6: combined underflow reloads both bytes
    a_r6_both_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade && hi_wrap) |=> lo_cnt == $past(lo_reload) && hi_cnt == $past(hi_reload));
    // R7: the square wave moves only with an underflow pulse
    a_r7_tout_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tout != $past(tout)) |-> lo_irq);
endmodule

// File: tb/casc_reload_timer_test.sv
module casc_reload_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cascade = 0, tick = 0, evt_in = 0, evt_mode = 0, evt_rise = 1;
    logic       lo_run = 0, lo_load = 0, hi_tick = 0, hi_run = 0, hi_load = 0, rd_en = 0;
    logic [7:0] lo_reload = 0, hi_reload = 0;
    logic [3:0] rd_data;
    logic       lo_irq, hi_irq, tout;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    // reference model state
    int m_lo = 0, m_hi = 0, m_seq = 0, m_snap = 0, m_rd = 0;
    int m_lirq = 0, m_hirq = 0, m_tout = 0, m_evq = 0;

    always #4 clk = ~clk;

    casc_reload_timer uut (
        .clk(clk), .rst_n(rst_n), .cascade(cascade), .tick(tick), .evt_in(evt_in),
        .evt_mode(evt_mode), .evt_rise(evt_rise), .lo_run(lo_run), .lo_load(lo_load),
        .lo_reload(lo_reload), .hi_tick(hi_tick), .hi_run(hi_run), .hi_load(hi_load),
        .hi_reload(hi_reload), .rd_en(rd_en), .rd_data(rd_data), .lo_irq(lo_irq),
        .hi_irq(hi_irq), .tout(tout)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected fewer", cycles);
            finish_run();
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int edge_hit, lstep, lwrap, hstep, hrun, hload, hwrap, act;
        edge_hit = evt_rise ? (evt_in && !m_evq) : (!evt_in && m_evq);
        m_evq = evt_in;
        lstep = evt_mode ? edge_hit : tick;              // R4
        lwrap = !lo_load && lo_run && lstep && (m_lo == 0);
        hstep = cascade ? lwrap : hi_tick;               // R5
        hrun  = cascade ? lo_run : hi_run;
        hload = cascade ? lo_load : hi_load;
        hwrap = !hload && hrun && hstep && (m_hi == 0);
        act   = cascade ? hwrap : lwrap;                 // R6
        if (rd_en) begin                                 // R8
            if (m_seq == 0) begin
                m_snap = (m_hi << 8) | m_lo;
                m_rd = m_lo & 15;
            end else m_rd = (m_snap >> (4 * m_seq)) & 15;
            m_seq = (m_seq + 1) % 4;
        end
        if (lo_load) m_lo = lo_reload;                   // R1
        else if (lo_run && lstep) m_lo = (m_lo == 0) ? lo_reload : m_lo - 1; // R2 R3
        if (hload) m_hi = hi_reload;
        else if (hrun && hstep) m_hi = (m_hi == 0) ? hi_reload : m_hi - 1;
        m_lirq = act;
        m_hirq = !cascade && hwrap;
        m_tout = m_tout ^ act;                           // R7
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            chk("R8 rd_data", rd_data, m_rd);
            chk("R3 lo_irq", lo_irq, m_lirq);
            chk("R6 hi_irq", hi_irq, m_hirq);
            chk("R7 tout", tout, m_tout);
        end
    endtask

    task automatic read4();
        for (int i = 0; i < 4; i++) begin
            rd_en = 1; cyc(1); rd_en = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        chk("R9 rd_data", rd_data, 0);
        chk("R9 lo_irq", lo_irq, 0);
        chk("R9 hi_irq", hi_irq, 0);
        chk("R9 tout", tout, 0);
        rst_n = 1;
        read4();
        // R1: load while stopped
        lo_reload = 8'h5A; hi_reload = 8'hC3;
        lo_load = 1; hi_load = 1; cyc(1); lo_load = 0; hi_load = 0;
        cyc(3);   // R2: stopped counters hold
        read4();
        // R2 R3: separate mode, low ticks every cycle
        lo_reload = 8'd3; lo_load = 1; cyc(1); lo_load = 0;
        lo_run = 1; tick = 1; cyc(12);
        read4();
        // high counter in separate mode with sparse tick
        hi_reload = 8'd2; hi_load = 1; cyc(1); hi_load = 0; hi_run = 1;
        for (int i = 0; i < 10; i++) begin hi_tick = 1; cyc(1); hi_tick = 0; cyc(1); end
        // R1: load while running
        lo_load = 1; cyc(1); lo_load = 0; cyc(2);
        // R4: event mode, rising then falling, tick held high
        evt_mode = 1; evt_rise = 1;
        for (int i = 0; i < 12; i++) begin evt_in = ~evt_in; cyc(2); end
        evt_rise = 0;
        for (int i = 0; i < 12; i++) begin evt_in = ~evt_in; cyc(1); end
        read4();
        evt_mode = 0;
        // R5 R6: cascade with high controls exercised
        cascade = 1; lo_reload = 8'd2; hi_reload = 8'd2;
        lo_load = 1; cyc(1); lo_load = 0;
        hi_run = 0;
        for (int i = 0; i < 20; i++) begin
            hi_tick = i[0]; hi_load = (i == 5); cyc(1);
        end
        hi_load = 0; read4();
        lo_run = 0; cyc(3); read4();
        lo_run = 1;
        // random mix
        for (int i = 0; i < 4000; i++) begin
            cascade   = ($urandom % 16) != 0 ? cascade : ~cascade;
            tick      = $urandom % 2;
            hi_tick   = $urandom % 2;
            evt_in    = $urandom % 2;
            evt_mode  = ($urandom % 32) == 0 ? ~evt_mode : evt_mode;
            evt_rise  = ($urandom % 32) == 0 ? ~evt_rise : evt_rise;
            lo_run    = ($urandom % 8) != 0;
            hi_run    = ($urandom % 8) != 0;
            lo_load   = ($urandom % 64) == 0;
            hi_load   = ($urandom % 64) == 0;
            lo_reload = 8'($urandom % 6);
            hi_reload = 8'($urandom % 4);
            rd_en     = ($urandom % 3) == 0;
            cyc(1);
        end
        rd_en = 0; lo_load = 0; hi_load = 0;
        cyc(2);
        finish_run();
    end
endmodule